// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block watches the command stream that a memory controller sends to a small multi-bank double-data-rate SDRAM. It keeps a model of every bank (idle, opening, row open, reading, writing, auto-precharge access, auto-precharge precharge, precharging). Each strobed command is judged against that model. Legal commands advance the model. Illegal ones are reported with a class code and leave every bank as it was. Typical uses are as a protocol monitor next to a controller or as a guard in front of a memory model.

All timing (row-to-column delay, precharge time, write recovery, burst length) comes from parameters and is counted in clock cycles. A burst of `BURST_LEN` beats occupies `BURST_LEN/2` clock cycles. The bank state that is output in a cycle is the state that a command applied in that cycle is checked against.

The checker follows an auto-precharge read or write in two phases: an access phase, then a precharge phase. Other banks may take only ACTIVE or PRECHARGE during the access phase. During the precharge phase they may also take READ and WRITE. Only one data burst may be in flight at a time.

Top module: `sdr_cmd_checker`

## Requirements
- R1: After reset every bank reports state IDLE (code 0) and `resp_valid_o` is 0.
- R2: ACTIVE (cmd 1) moves an IDLE bank to OPENING (state 1) and then to ROW_OPEN (state 2). READ (2), READ-AP (3), WRITE (4) and WRITE-AP (5) to a bank become legal once `T_RCD` cycles have passed since its ACTIVE. A READ or WRITE to a bank that is not in state 2 gives error 1 (bank state).
- R3: ACTIVE to a bank that is not IDLE gives error 1.
- R4: PRECHARGE (cmd 6) to a ROW_OPEN bank moves it to PRECHARGING (state 8), and it is IDLE again `T_RP` cycles later. PRECHARGE to an IDLE bank is legal and changes nothing. PRECHARGE in any other state gives error 1.
- R5: AUTO REFRESH (cmd 8) and LOAD MODE (cmd 9) are legal only when all banks are IDLE. Otherwise they give error 2 (not all idle).
- R6: BURST STOP (cmd 7) is legal only to the bank holding a plain READ burst (state 3), which then returns to ROW_OPEN at once. To any other bank, including one in a READ-AP access, it gives error 1.
- R7: A READ burst (state 3) lasts `BURST_LEN/2` cycles. While any bank is in state 3 or state 4, a READ or WRITE to a ROW_OPEN bank gives error 3 (contention). A WRITE is therefore legal after a read only once that burst ends or has been stopped.
- R8: A WRITE (state 4) lasts `BURST_LEN/2 + T_WR` cycles before the bank is ROW_OPEN again. A PRECHARGE during this time gives error 1.
- R9: READ-AP puts the bank in AP_ACCESS_RD (state 5) for `BURST_LEN/2` cycles, then in AP_PRECHARGE (state 7) for `T_RP` cycles, then IDLE.
- R10: WRITE-AP puts the bank in AP_ACCESS_WR (state 6) for `BURST_LEN/2 + T_WR` cycles, then in AP_PRECHARGE (state 7) for `T_RP` cycles, then IDLE.
- R11: While a bank is in state 5 or 6, a READ or WRITE to another ROW_OPEN bank gives error 4 (auto-precharge period), while ACTIVE and PRECHARGE to other banks stay legal. In state 7, READ and WRITE to other banks are legal. For READ and WRITE the error priority is 1, then 4, then 3.
- R12: An illegal command changes no bank state. Opcodes 10 to 15 give error 5 (unknown command). `legal_o` is 1 exactly when the error code is 0.
- R13: A command counts only when `cmd_valid_i` is 1. Its verdict appears on `resp_valid_o`, `legal_o` and `err_code_o` one clock edge later, together with the updated bank states. Without the strobe, no response is given and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe for this cycle |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | BANK_W | Target bank |
| bank_state_o | output | NUM_BANKS*4 | State code of each bank, bank b in bits [4b+3:4b] |
| resp_valid_o | output | 1 | Verdict for the previous cycle's command is valid |
| legal_o | output | 1 | Previous command was legal |
| err_code_o | output | 3 | Violation class of previous command (0 = none) |

## Verification
A command is captured at a rising edge, and its verdict and the resulting bank states are visible right after that same edge. The bench therefore drives on falling edges and checks the response at the very next falling edge. Timer expiry follows a fixed rule: a phase entered at edge e with length T lets the next phase be seen after edge e+T-1, so a command at edge e+T is judged against it. The sweeps vary the command gap k from 1 to one past each limit and expect legal exactly when k reaches the parameter-derived length. The auto-precharge state walks compare each sampled cycle j against the same arithmetic.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

  localparam int unsigned ST_W = 4;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_BST  = 4'd7,
    CMD_REF  = 4'd8,
    CMD_LMR  = 4'd9
  } cmd_e;

  typedef enum logic [ST_W-1:0] {
    BS_IDLE   = 4'd0,
    BS_OPEN   = 4'd1,
    BS_ACTIVE = 4'd2,
    BS_READ   = 4'd3,
    BS_WRITE  = 4'd4,
    BS_RDA    = 4'd5,
    BS_WRA    = 4'd6,
    BS_APRE   = 4'd7,
    BS_PRE    = 4'd8
  } bank_st_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_STATE    = 3'd1,
    ERR_NOT_IDLE = 3'd2,
    ERR_CONTEND  = 3'd3,
    ERR_AP       = 3'd4,
    ERR_OPCODE   = 3'd5
  } err_e;

  function automatic logic is_rw(cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
  import sdr_chk_pkg::*;
#(
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  cmd_e     cmd_i,
  output bank_st_e state_o
);

  localparam int unsigned BURST_CYC = BURST_LEN / 2;
  localparam int unsigned WR_CYC    = BURST_CYC + T_WR;
  localparam int unsigned MAX_A     = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned MAX_CYC   = (MAX_A > WR_CYC) ? MAX_A : WR_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             timed;

  function automatic logic [CNT_W-1:0] first_cnt(int unsigned cyc);
    return CNT_W'(cyc - 1);
  endfunction

  assign timed = st_q inside {BS_OPEN, BS_READ, BS_WRITE, BS_RDA, BS_WRA, BS_APRE, BS_PRE};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (timed) begin
      if (cnt_q == CNT_W'(1)) begin
        unique case (st_q)
          // precharge phase starts one cycle later than a phase entered by a command
          BS_RDA, BS_WRA: begin
            st_d  = BS_APRE;
            cnt_d = CNT_W'(T_RP);
          end
          BS_APRE, BS_PRE: st_d = BS_IDLE;
          default:         st_d = BS_ACTIVE;
        endcase
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (hit_i) begin
      case (cmd_i)
        CMD_ACT: begin
          st_d  = BS_OPEN;
          cnt_d = first_cnt(T_RCD);
        end
        CMD_RD: begin
          st_d  = BS_READ;
          cnt_d = first_cnt(BURST_CYC);
        end
        CMD_RDA: begin
          st_d  = BS_RDA;
          cnt_d = first_cnt(BURST_CYC);
        end
        CMD_WR: begin
          st_d  = BS_WRITE;
          cnt_d = first_cnt(WR_CYC);
        end
        CMD_WRA: begin
          st_d  = BS_WRA;
          cnt_d = first_cnt(WR_CYC);
        end
        CMD_PRE: begin
          if (st_q == BS_ACTIVE) begin
            st_d  = BS_PRE;
            cnt_d = first_cnt(T_RP);
          end
        end
        CMD_BST: begin
          st_d  = BS_ACTIVE;
          cnt_d = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/sdr_cmd_rules.sv
module sdr_cmd_rules
  import sdr_chk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  bank_st_e          state_i [NUM_BANKS],
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              legal_o,
  output err_e              err_o
);

  logic     all_idle;
  logic     burst_busy;
  logic     ap_access;
  bank_st_e tgt;

  always_comb begin
    all_idle   = 1'b1;
    burst_busy = 1'b0;
    ap_access  = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (state_i[b] != BS_IDLE) all_idle = 1'b0;
      if (state_i[b] inside {BS_READ, BS_WRITE}) burst_busy = 1'b1;
      if (state_i[b] inside {BS_RDA, BS_WRA}) ap_access = 1'b1;
    end
  end

  assign tgt = state_i[bank_i];

  always_comb begin
    err_o = ERR_NONE;
    case (cmd_i)
      CMD_NOP: err_o = ERR_NONE;
      CMD_ACT: if (tgt != BS_IDLE) err_o = ERR_STATE;
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
        // target open implies any auto-precharge access is on another bank
        if (tgt != BS_ACTIVE)  err_o = ERR_STATE;
        else if (ap_access)    err_o = ERR_AP;
        else if (burst_busy)   err_o = ERR_CONTEND;
      end
      CMD_PRE: if (!(tgt inside {BS_IDLE, BS_ACTIVE})) err_o = ERR_STATE;
      CMD_BST: if (tgt != BS_READ) err_o = ERR_STATE;
      CMD_REF, CMD_LMR: if (!all_idle) err_o = ERR_NOT_IDLE;
      default: err_o = ERR_OPCODE;
    endcase
  end

  assign legal_o = (err_o == ERR_NONE);

endmodule

// File: rtl/sdr_cmd_checker.sv
module sdr_cmd_checker
  import sdr_chk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [3:0]                cmd_i,
  input  logic [BANK_W-1:0]         bank_i,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  output logic                      resp_valid_o,
  output logic                      legal_o,
  output logic [2:0]                err_code_o
);

  cmd_e     cmd;
  bank_st_e st [NUM_BANKS];
  logic     legal;
  err_e     err;
  logic     resp_q, legal_q;
  err_e     err_q;

  assign cmd = cmd_e'(cmd_i);

  sdr_cmd_rules #(
    .NUM_BANKS(NUM_BANKS)
  ) i_rules (
    .state_i(st),
    .cmd_i  (cmd),
    .bank_i (bank_i),
    .legal_o(legal),
    .err_o  (err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = cmd_valid_i && legal && (bank_i == BANK_W'(b));

    sdr_bank_fsm #(
      .T_RCD    (T_RCD),
      .T_RP     (T_RP),
      .T_WR     (T_WR),
      .BURST_LEN(BURST_LEN)
    ) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit),
      .cmd_i  (cmd),
      .state_o(st[b])
    );

    assign bank_state_o[b*ST_W +: ST_W] = st[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q  <= 1'b0;
      legal_q <= 1'b1;
      err_q   <= ERR_NONE;
    end else begin
      resp_q  <= cmd_valid_i;
      legal_q <= cmd_valid_i ? legal : 1'b1;
      err_q   <= cmd_valid_i ? err : ERR_NONE;
    end
  end

  assign resp_valid_o = resp_q;
  assign legal_o      = legal_q;
  assign err_code_o   = err_q;

endmodule

// File: rtl/sdr_cmd_checker_sva.sv
module sdr_cmd_checker_sva
  import sdr_chk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_valid_i,
  input logic [3:0]                cmd_i,
  input logic [BANK_W-1:0]         bank_i,
  input logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  input logic                      resp_valid_o,
  input logic                      legal_o,
  input logic [2:0]                err_code_o
);

  logic [ST_W-1:0] tgt;
  assign tgt = bank_state_o[bank_i*ST_W +: ST_W];

  AST_NO_RESP_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !resp_valid_o); // R13

  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (legal_o == (err_code_o == 3'd0))); // R12

  AST_REFRESH_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_i == CMD_REF || cmd_i == CMD_LMR) && (bank_state_o != '0))
    |=> (!legal_o && err_code_o == 3'd2)); // R5

  AST_ACT_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_ACT && tgt != BS_IDLE) |=> (err_code_o == 3'd1)); // R3

  AST_STOP_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_BST && tgt != BS_READ) |=> (err_code_o == 3'd1)); // R6

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[b*ST_W +: ST_W] == BS_IDLE &&
       !(cmd_valid_i && cmd_i == CMD_ACT && bank_i == BANK_W'(b)))
      |=> (bank_state_o[b*ST_W +: ST_W] == BS_IDLE)); // R12
  end

endmodule

bind sdr_cmd_checker sdr_cmd_checker_sva #(
  .NUM_BANKS(NUM_BANKS)
) i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .bank_state_o(bank_state_o),
  .resp_valid_o(resp_valid_o),
  .legal_o     (legal_o),
  .err_code_o  (err_code_o)
);

// File: tb/test_sdr_cmd_checker.sv
`timescale 1ns/1ps
module test_sdr_cmd_checker;

  localparam int NB   = 4;
  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int TWR  = 2;
  localparam int BL   = 4;
  localparam int BC   = BL / 2;
  localparam int WC   = BC + TWR;

  localparam logic [3:0] C_ACT = 4'd1, C_RD = 4'd2, C_RDA = 4'd3, C_WR = 4'd4,
                         C_WRA = 4'd5, C_PRE = 4'd6, C_BST = 4'd7, C_REF = 4'd8, C_LMR = 4'd9;
  localparam int S_IDLE = 0, S_OPEN = 1, S_ACT = 2, S_RDA = 5, S_WRA = 6, S_APRE = 7, S_PRE = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [3:0]      cmd = '0;
  logic [1:0]      bank = '0;
  logic [NB*4-1:0] bank_state;
  logic            resp_valid, legal;
  logic [2:0]      err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdr_cmd_checker #(
    .NUM_BANKS(NB), .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR), .BURST_LEN(BL)
  ) i_sdr_cmd_checker (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .bank_i(bank),
    .bank_state_o(bank_state), .resp_valid_o(resp_valid), .legal_o(legal), .err_code_o(err)
  );

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_state(string r, int b, int exp);
    chk(r, int'(bank_state[b*4 +: 4]), exp);
  endtask

  task automatic chk_resp(string r, bit exp_legal, int exp_err);
    checks++;
    if (!(resp_valid && legal == exp_legal && int'(err) == exp_err)) begin
      errors++;
      $display("FAIL %s: actual valid=%0d legal=%0d err=%0d expected valid=1 legal=%0d err=%0d",
               r, resp_valid, legal, err, exp_legal, exp_err);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [3:0] c, int b);
    cmd_valid = 1'b1;
    cmd = c;
    bank = 2'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = '0;
  endtask

  task automatic open_bank(int b);
    issue(C_ACT, b);
    idle(TRCD - 1);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int b = 0; b < NB; b++) chk_state("R1 reset state", b, S_IDLE);
    chk("R1 resp_valid after reset", int'(resp_valid), 0);

    // R2 row-to-column sweep
    for (int k = 1; k <= TRCD + 1; k++) begin
      do_reset();
      issue(C_ACT, 0);
      chk_state("R2 opening after ACT", 0, (TRCD > 1) ? S_OPEN : S_ACT);
      idle(k - 1);
      issue((k % 2 == 1) ? C_WR : C_RD, 0);
      chk_resp("R2 access vs tRCD", k >= TRCD, (k >= TRCD) ? 0 : 1);
    end

    // R3 ACT to non-idle banks
    do_reset();
    open_bank(1);
    issue(C_ACT, 1);
    chk_resp("R3 ACT to open bank", 0, 1);
    chk_state("R12 open bank unchanged", 1, S_ACT);
    issue(C_ACT, 2);
    issue(C_ACT, 2);
    chk_resp("R3 ACT to opening bank", 0, 1);
    chk_state("R12 opening bank unchanged", 2, (1 < TRCD - 1) ? S_OPEN : S_ACT);

    // R4 precharge sweep
    for (int k = 1; k <= TRP + 1; k++) begin
      do_reset();
      open_bank(0);
      issue(C_PRE, 0);
      chk_resp("R4 PRE open bank", 1, 0);
      chk_state("R4 precharging", 0, S_PRE);
      idle(k - 1);
      issue(C_ACT, 0);
      chk_resp("R4 ACT vs tRP", k >= TRP, (k >= TRP) ? 0 : 1);
    end
    issue(C_PRE, 3);
    chk_resp("R4 PRE idle bank", 1, 0);
    chk_state("R4 idle bank stays idle", 3, S_IDLE);

    // R5 refresh / mode load
    do_reset();
    issue(C_REF, 0);
    chk_resp("R5 REF all idle", 1, 0);
    issue(C_LMR, 0);
    chk_resp("R5 LMR all idle", 1, 0);
    issue(C_ACT, 2);
    issue(C_REF, 0);
    chk_resp("R5 REF bank busy", 0, 2);
    issue(C_LMR, 1);
    chk_resp("R5 LMR bank busy", 0, 2);
    idle(TRCD);
    issue(C_PRE, 2);
    idle(TRP - 1);
    issue(C_REF, 0);
    chk_resp("R5 REF after precharge", 1, 0);

    // R6 burst stop
    do_reset();
    open_bank(0);
    open_bank(1);
    issue(C_RD, 0);
    issue(C_BST, 0);
    chk_resp("R6 BST reading bank", 1, 0);
    chk_state("R6 stopped bank open", 0, S_ACT);
    issue(C_WR, 1);
    chk_resp("R7 WR after BST", 1, 0);
    do_reset();
    open_bank(0);
    open_bank(1);
    issue(C_RD, 0);
    issue(C_BST, 1);
    chk_resp("R6 BST other bank", 0, 1);
    chk_state("R12 other bank unchanged", 1, S_ACT);
    issue(C_BST, 3);
    chk_resp("R6 BST idle bank", 0, 1);
    do_reset();
    open_bank(0);
    issue(C_RDA, 0);
    issue(C_BST, 0);
    chk_resp("R6 BST auto-precharge read", 0, 1);

    // R7 contention sweeps
    for (int k = 1; k <= BC + 1; k++) begin
      do_reset();
      open_bank(0);
      open_bank(1);
      issue(C_RD, 0);
      idle(k - 1);
      issue(C_WR, 1);
      chk_resp("R7 WR after read burst", k >= BC, (k >= BC) ? 0 : 3);
    end
    for (int k = 1; k <= WC + 1; k++) begin
      do_reset();
      open_bank(0);
      open_bank(1);
      issue(C_WR, 0);
      idle(k - 1);
      issue(C_RD, 1);
      chk_resp("R7 RD after write", k >= WC, (k >= WC) ? 0 : 3);
    end

    // R8 write recovery
    for (int k = 1; k <= WC + 1; k++) begin
      do_reset();
      open_bank(0);
      issue(C_WR, 0);
      idle(k - 1);
      issue(C_PRE, 0);
      chk_resp("R8 PRE after write", k >= WC, (k >= WC) ? 0 : 1);
    end

    // R9 read with auto precharge walk
    do_reset();
    open_bank(0);
    issue(C_RDA, 0);
    for (int j = 0; j <= BC + TRP; j++) begin
      chk_state("R9 read-ap phase", 0, (j < BC - 1) ? S_RDA : (j < BC + TRP - 1) ? S_APRE : S_IDLE);
      idle(1);
    end
    issue(C_ACT, 0);
    chk_resp("R9 ACT after read-ap", 1, 0);

    // R10 write with auto precharge walk
    do_reset();
    open_bank(0);
    issue(C_WRA, 0);
    for (int j = 0; j <= WC + TRP; j++) begin
      chk_state("R10 write-ap phase", 0, (j < WC - 1) ? S_WRA : (j < WC + TRP - 1) ? S_APRE : S_IDLE);
      idle(1);
    end

    // R11 other-bank rules around auto precharge
    for (int k = 1; k <= WC + 1; k++) begin
      do_reset();
      open_bank(0);
      open_bank(1);
      issue(C_WRA, 0);
      idle(k - 1);
      issue(C_RD, 1);
      chk_resp("R11 RD during write-ap", k >= WC, (k >= WC) ? 0 : 4);
    end
    do_reset();
    open_bank(0);
    open_bank(1);
    issue(C_WRA, 0);
    issue(C_ACT, 2);
    chk_resp("R11 ACT during access", 1, 0);
    issue(C_PRE, 1);
    chk_resp("R11 PRE during access", 1, 0);
    issue(C_WR, 3);
    chk_resp("R11 state error has priority", 0, 1);

    // R12 unknown opcodes
    for (int c = 10; c <= 15; c++) begin
      do_reset();
      open_bank(1);
      issue(4'(c), 1);
      chk_resp("R12 unknown opcode", 0, 5);
      chk_state("R12 state kept", 1, S_ACT);
    end

    // R13 strobe
    do_reset();
    open_bank(0);
    cmd = C_PRE;
    bank = 2'd0;
    @(negedge clk);
    chk("R13 no resp without strobe", int'(resp_valid), 0);
    chk_state("R13 no change without strobe", 0, S_ACT);
    cmd = '0;
    issue(C_PRE, 0);
    chk("R13 resp after strobe", int'(resp_valid), 1);
    idle(1);
    chk("R13 resp drops", int'(resp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule